// File: doc/BRIEF.md
# Triggered Event Capture and Serial Readout Sequencer

This controller steps a 36-channel front-end through three phases. Each phase has its own start pulse. During acquisition, every clock cycle in which any channel trigger is high takes the next free slot of a 16-entry event store. The slot keeps the 36-bit pattern of channels that fired and the 8-bit bunch-crossing tag present in that cycle.

A conversion pulse closes acquisition. The controller then visits the filled slots one per cycle, announcing each slot index to the converter and copying the slot record into the readout RAM.

A readout pulse then shifts the chip identifier out on one serial line, followed by every filled record. Transmit-active and end-of-readout flags let the next chip in a daisy chain take over. An empty acquisition is flagged and skips transmission altogether.

Top module: `evt_readout_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is low after that edge: `full`, `no_trig`, `conv_strobe`, `conv_end`, `tx_on`, `sdo` and `end_rd`.
- R2: A `start_acq` pulse in the idle phase opens acquisition. It empties the event store and clears `full` and `no_trig`.
- R3: In acquisition, each cycle with a nonzero `trig` writes the record {`bx_tag`, `trig`} into the next slot, in order starting from slot 0.
- R4: `full` rises in the cycle after the 16th slot is written. Any later trigger in the same acquisition stores nothing.
- R5: Triggers outside acquisition store nothing: not in idle before `start_acq`, and not after `start_conv`.
- R6: `start_conv` closes acquisition. A trigger present in the same cycle is still stored as the last record.
- R7: After `start_conv`, `conv_strobe` is high for n consecutive cycles (n = stored slots), with `conv_slot` counting 0 to n-1. This is followed by exactly one cycle of `conv_end`.
- R8: After `start_read` the serial stream is: the 8-bit `chip_id` MSB first; then, for each stored slot in order, the 8-bit tag MSB first and then the 36-bit mask from bit 35 down to bit 0. Total length is 8 + 44·n bits, one bit per cycle, starting the cycle after `start_read`.
- R9: `tx_on` is high in exactly the cycles that carry a stream bit. `sdo` is low whenever `tx_on` is low.
- R10: `end_rd` is high for one cycle, directly after the last stream bit. The controller is then idle.
- R11: If no slot was stored, `no_trig` is high from the cycle after `start_conv` until the next `start_acq`. `start_read` then sends nothing, and `end_rd` is high in the following cycle.
- R12: A reset in the middle of acquisition returns to idle, so that `start_conv` without a new `start_acq` does nothing, and discards the stored slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_acq | input | 1 | Opens acquisition (idle only) |
| start_conv | input | 1 | Closes acquisition, starts conversion stepping |
| start_read | input | 1 | Starts serial readout |
| trig | input | 36 | Per-channel trigger pattern |
| bx_tag | input | 8 | Current bunch-crossing tag |
| chip_id | input | 8 | Identifier sent at the head of the stream |
| full | output | 1 | All 16 slots used |
| no_trig | output | 1 | Acquisition ended with no stored slot |
| conv_strobe | output | 1 | Conversion request for `conv_slot` |
| conv_slot | output | 4 | Slot being converted |
| conv_end | output | 1 | One-cycle end of conversion |
| tx_on | output | 1 | Serial data is being driven |
| sdo | output | 1 | Serial data |
| end_rd | output | 1 | One-cycle end of readout |

## Verification
Capture of a trigger and the close of acquisition can land on the same edge. The bench provokes this by raising the last trigger together with `start_conv` for every odd event count up to 16. It then judges the result by finding that record at the tail of the serial stream, and by the strobe count in the conversion phase. A second collision, a trigger arriving with the store already full, is driven by a 17-trigger run; the stream must still hold exactly 16 records. Expected streams are rebuilt bit by bit from arithmetic mask and tag formulas for every count from 0 to 17.

// File: rtl/evt_seq_pkg.sv
`timescale 1ns/1ps
// Shared phase encoding for the event capture and readout sequencer.
package evt_seq_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ACQ,
        PH_CONV,
        PH_CRDY,
        PH_SEND,
        PH_FIN
    } phase_t;
endpackage

// File: rtl/evt_slot_store.sv
`timescale 1ns/1ps
// Event slot store: an ordered write-only queue of DEPTH records of
// {tag, mask}. Writes land at the current fill count. Writes when full are
// dropped. Assumes DEPTH >= 2. Read is asynchronous by index.
module evt_slot_store #(
    parameter int NCH   = 36,
    parameter int DEPTH = 16,
    parameter int TAGW  = 8,
    localparam int REC  = TAGW + NCH,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            wr,
    input  logic [TAGW-1:0] tag,
    input  logic [NCH-1:0]  mask,
    input  logic [AW-1:0]   rd_idx,
    output logic [REC-1:0]  rd_rec,
    output logic [CW-1:0]   count,
    output logic            full
);
    logic [REC-1:0] mem [DEPTH];

    assign full   = (count == CW'(DEPTH));
    assign rd_rec = mem[rd_idx];

    // Fill counter: cleared by reset or a new acquisition, advanced by accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n)          count <= '0;
        else if (clr)        count <= '0;
        else if (wr && !full) count <= count + CW'(1);
    end

    // Record storage: writes go to the slot named by the fill count.
    always_ff @(posedge clk) begin
        if (wr && !full) mem[count[AW-1:0]] <= {tag, mask};
    end

    // R4: once full, the store stays full until cleared.
    p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clr) |=> full);
    // R3: the count moves by at most one slot per cycle.
    p_one_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (count == $past(count) || count == $past(count) + CW'(1)));
endmodule

// File: rtl/evt_serializer.sv
`timescale 1ns/1ps
// Serial stream builder: sends the IDW-bit identifier MSB first, then nrec
// records of REC bits each, MSB first, fetched by index from the readout RAM.
// One bit per cycle. Assumes IDW <= REC and nrec stays stable while busy.
module evt_serializer #(
    parameter int REC   = 44,
    parameter int IDW   = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int LW   = $clog2(REC + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic [CW-1:0]  nrec,
    input  logic [IDW-1:0] chip_id,
    input  logic [REC-1:0] rec,
    output logic [AW-1:0]  addr,
    output logic           busy,
    output logic           last,
    output logic           sdo
);
    logic [REC-1:0] sh;
    logic [LW-1:0]  left;
    logic [CW-1:0]  nxt;

    assign addr = nxt[AW-1:0];
    assign last = busy && (left == LW'(1)) && (nxt == nrec);
    assign sdo  = busy && sh[REC-1];

    // Shift engine: loads the identifier on go, then each record in turn.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            sh   <= '0;
            left <= '0;
            nxt  <= '0;
        end else if (go) begin
            busy <= 1'b1;
            sh   <= {chip_id, {(REC-IDW){1'b0}}};
            left <= LW'(IDW);
            nxt  <= '0;
        end else if (busy) begin
            if (left == LW'(1)) begin
                if (nxt < nrec) begin
                    sh   <= rec;
                    left <= LW'(REC);
                    nxt  <= nxt + CW'(1);
                end else begin
                    busy <= 1'b0;
                    left <= '0;
                end
            end else begin
                sh   <= {sh[REC-2:0], 1'b0};
                left <= left - LW'(1);
            end
        end
    end

    // R9: a busy serializer always has a bit in flight.
    p_bit_in_flight_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (left != '0));
    // R8: records are never fetched beyond the requested count.
    p_fetch_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (nxt <= nrec));
endmodule

// File: rtl/evt_readout_seq.sv
`timescale 1ns/1ps
// Acquisition, conversion and serial readout sequencer for one front-end chip.
// Phases: idle -> acquisition -> conversion stepping -> ready -> sending -> end.
// Each phase is started by its own pulse, accepted only in the preceding phase.
// Conversion copies each stored slot into the readout RAM, one per cycle.
module evt_readout_seq
    import evt_seq_pkg::*;
#(
    parameter int NCH   = 36,
    parameter int DEPTH = 16,
    parameter int TAGW  = 8,
    parameter int IDW   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_acq,
    input  logic                     start_conv,
    input  logic                     start_read,
    input  logic [NCH-1:0]           trig,
    input  logic [TAGW-1:0]          bx_tag,
    input  logic [IDW-1:0]           chip_id,
    output logic                     full,
    output logic                     no_trig,
    output logic                     conv_strobe,
    output logic [$clog2(DEPTH)-1:0] conv_slot,
    output logic                     conv_end,
    output logic                     tx_on,
    output logic                     sdo,
    output logic                     end_rd
);
    localparam int REC = TAGW + NCH;
    localparam int AW  = $clog2(DEPTH);
    localparam int CW  = $clog2(DEPTH + 1);

    phase_t         ph;
    logic [CW-1:0]  n_evt;
    logic [CW-1:0]  cidx;
    logic           st_full;
    logic           no_trig_q;
    logic           acq_clr, acq_wr, ser_go, ser_last, ser_busy;
    logic [REC-1:0] st_rec, ram_rec;
    logic [AW-1:0]  ser_addr;
    logic [REC-1:0] ram [DEPTH];

    assign acq_clr = (ph == PH_IDLE) && start_acq;
    assign acq_wr  = (ph == PH_ACQ) && (|trig);
    assign ser_go  = (ph == PH_CRDY) && start_read && (n_evt != '0);

    evt_slot_store #(.NCH(NCH), .DEPTH(DEPTH), .TAGW(TAGW)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (acq_clr),
        .wr     (acq_wr),
        .tag    (bx_tag),
        .mask   (trig),
        .rd_idx (cidx[AW-1:0]),
        .rd_rec (st_rec),
        .count  (n_evt),
        .full   (st_full)
    );

    assign ram_rec = ram[ser_addr];

    evt_serializer #(.REC(REC), .IDW(IDW), .DEPTH(DEPTH)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (ser_go),
        .nrec    (n_evt),
        .chip_id (chip_id),
        .rec     (ram_rec),
        .addr    (ser_addr),
        .busy    (ser_busy),
        .last    (ser_last),
        .sdo     (sdo)
    );

    assign full        = st_full;
    assign no_trig     = no_trig_q;
    assign conv_strobe = (ph == PH_CONV) && (cidx < n_evt);
    assign conv_slot   = cidx[AW-1:0];
    assign conv_end    = (ph == PH_CONV) && (cidx == n_evt);
    assign tx_on       = ser_busy;
    assign end_rd      = (ph == PH_FIN);

    // Phase sequencer: advances on start pulses and on completion of each phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph        <= PH_IDLE;
            cidx      <= '0;
            no_trig_q <= 1'b0;
        end else begin
            case (ph)
                PH_IDLE: if (start_acq) begin
                    ph        <= PH_ACQ;
                    no_trig_q <= 1'b0;
                end
                PH_ACQ: if (start_conv) begin
                    ph        <= PH_CONV;
                    cidx      <= '0;
                    no_trig_q <= (n_evt == '0) && !acq_wr;
                end
                PH_CONV: begin
                    if (cidx < n_evt) cidx <= cidx + CW'(1);
                    else              ph   <= PH_CRDY;
                end
                PH_CRDY: if (start_read) ph <= (n_evt == '0) ? PH_FIN : PH_SEND;
                PH_SEND: if (ser_last)   ph <= PH_FIN;
                PH_FIN:  ph <= PH_IDLE;
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // Readout RAM fill: each conversion strobe copies its slot record.
    always_ff @(posedge clk) begin
        if (conv_strobe) ram[cidx[AW-1:0]] <= st_rec;
    end

    // R7: a strobed slot index is always a stored slot.
    p_strobe_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        conv_strobe |-> (conv_slot < AW'(n_evt)) || (n_evt == CW'(DEPTH)));
    // R10: end of readout lasts a single cycle.
    p_end_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        end_rd |=> !end_rd);
    // R9: transmission never overlaps conversion or the end pulse.
    p_tx_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_on |-> (!end_rd && !conv_strobe && !conv_end));
    // R11: the empty flag is only ever shown with an empty store.
    p_notrig_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        no_trig |-> (n_evt == '0));
    // R5: outside acquisition and its clear, the store count cannot move.
    p_hold_outside_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ph != PH_ACQ && !acq_clr) |=> (n_evt == $past(n_evt)));
endmodule

// File: tb/evt_readout_seq_tb.sv
`timescale 1ns/1ps
module evt_readout_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n, start_acq, start_conv, start_read;
    logic [35:0] trig;
    logic [7:0]  bx_tag, chip_id;
    logic        full, no_trig, conv_strobe, conv_end, tx_on, sdo, end_rd;
    logic [3:0]  conv_slot;
    int          n_pass = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    evt_readout_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_acq(start_acq), .start_conv(start_conv),
        .start_read(start_read), .trig(trig), .bx_tag(bx_tag), .chip_id(chip_id),
        .full(full), .no_trig(no_trig), .conv_strobe(conv_strobe), .conv_slot(conv_slot),
        .conv_end(conv_end), .tx_on(tx_on), .sdo(sdo), .end_rd(end_rd)
    );

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        if (ok) n_pass++;
        else begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] emask(input int n, input int k);
        logic [31:0] lo;
        lo = 32'(32'h9E3779B9 * (k + 1)) ^ 32'(n * 32'h01010101);
        return {4'(k + 1), lo} | 36'h1;
    endfunction

    function automatic logic [7:0] etag(input int n, input int k);
        return 8'(n * 13 + k * 7 + 3);
    endfunction

    task automatic outs_low(input string req);
        chk(!full && !no_trig && !conv_strobe && !conv_end && !tx_on && !sdo && !end_rd, req,
            {57'd0, full, no_trig, conv_strobe, conv_end, tx_on, sdo, end_rd}, 64'd0);
    endtask

    task automatic run_case(input int n);
        int nst, co, tot;
        logic [7:0]  cid;
        logic [43:0] rec;
        logic        eb;
        nst = (n > 16) ? 16 : n;
        co  = ((n % 2) == 1 && n <= 16) ? 1 : 0;
        cid = 8'(8'hA5 ^ (n * 17));
        // R5: trigger while idle must not be stored
        trig = emask(99, n); bx_tag = 8'hEE; @(negedge clk); trig = '0;
        start_acq = 1'b1; @(negedge clk); start_acq = 1'b0;
        chk(!no_trig, "R2 no_trig cleared", no_trig, 0);
        chk(!full, "R2 full cleared", full, 0);
        for (int k = 0; k < n - co; k++) begin
            trig = emask(n, k); bx_tag = etag(n, k);
            @(negedge clk); trig = '0;
            chk(full == (k + 1 >= 16), "R4 full flag", full, (k + 1 >= 16));
            if (k % 3 == 0) @(negedge clk);
        end
        start_conv = 1'b1;
        if (co == 1) begin trig = emask(n, n - 1); bx_tag = etag(n, n - 1); end   // R6 collision
        @(negedge clk); start_conv = 1'b0; trig = '0;
        chk(no_trig == (nst == 0), "R11 no_trig", no_trig, (nst == 0));
        for (int s = 0; s < nst; s++) begin
            chk(conv_strobe && conv_slot == 4'(s) && !conv_end, "R7 strobe", {conv_strobe, conv_slot}, {1'b1, 4'(s)});
            @(negedge clk);
        end
        chk(conv_end && !conv_strobe, "R7 conv_end", {conv_end, conv_strobe}, 2'b10);
        @(negedge clk);
        chk(!conv_end && !conv_strobe, "R7 single end", {conv_end, conv_strobe}, 0);
        // R5: trigger after conversion must not be stored
        trig = emask(77, n); bx_tag = 8'hFF; @(negedge clk); trig = '0;
        chip_id = cid; start_read = 1'b1; @(negedge clk); start_read = 1'b0;
        if (nst == 0) begin
            chk(end_rd && !tx_on && !sdo, "R11 empty readout", {end_rd, tx_on, sdo}, 3'b100);
        end else begin
            tot = 8 + 44 * nst;
            for (int b = 0; b < tot; b++) begin
                if (b < 8) eb = cid[7 - b];
                else begin
                    rec = {etag(n, (b - 8) / 44), emask(n, (b - 8) / 44)};
                    eb  = rec[43 - ((b - 8) % 44)];
                end
                chk(tx_on && !end_rd, "R9 tx_on during stream", {tx_on, end_rd}, 2'b10);
                chk(sdo == eb, "R8 stream bit", sdo, eb);
                @(negedge clk);
            end
            chk(!tx_on && !sdo, "R9 tx_on after stream", {tx_on, sdo}, 0);
            chk(end_rd, "R10 end_rd after last bit", end_rd, 1);
        end
        @(negedge clk);
        chk(!end_rd && !tx_on, "R10 end_rd single cycle", {end_rd, tx_on}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_acq = 1'b0; start_conv = 1'b0; start_read = 1'b0;
        trig = '0; bx_tag = '0; chip_id = '0;
        repeat (3) @(negedge clk);
        outs_low("R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        for (int n = 0; n <= 17; n++) run_case(n);
        // R12: reset during acquisition
        start_acq = 1'b1; @(negedge clk); start_acq = 1'b0;
        for (int k = 0; k < 3; k++) begin
            trig = emask(5, k); @(negedge clk);
        end
        trig = '0; rst_n = 1'b0; @(negedge clk);
        outs_low("R12 reset mid acquisition");
        rst_n = 1'b1; @(negedge clk);
        start_conv = 1'b1; @(negedge clk); start_conv = 1'b0;
        chk(!conv_end && !conv_strobe && !no_trig, "R12 idle after reset", {conv_end, conv_strobe, no_trig}, 0);
        start_acq = 1'b1; @(negedge clk); start_acq = 1'b0;
        start_conv = 1'b1; @(negedge clk); start_conv = 1'b0;
        chk(no_trig && conv_end, "R12 store emptied", {no_trig, conv_end}, 2'b11);
        @(negedge clk);
        start_read = 1'b1; @(negedge clk); start_read = 1'b0;
        chk(end_rd && !tx_on, "R12 empty readout", {end_rd, tx_on}, 2'b10);
        @(negedge clk);
        $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
        $finish;
    end
endmodule